// File: doc/BRIEF.md
# Segmented String Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address. The segment value is shifted left by four bit positions and the offset is added to it. A role input chooses the segment and the offset source:

- Code fetch, stack access and plain data access each take their offset from an input port.
- The two string roles take their offset from the internal source and destination pointers.

The block holds four segment registers, the source and destination pointers, a repeat counter and a direction bit. All of them are loaded through one synchronous write port.

A string engine drives the element step input once per element moved. On each accepted step, both pointers move by the element size, in the direction held by the direction bit. When repeat mode is on, the counter also counts down by one. The done output reports a zero count. In repeat mode, a step that arrives with a zero count is ignored.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment × 16 + offset) modulo 2^20, so a sum that carries past bit 19 wraps around.
- R2: Role 0 pairs the code segment with the `offset` input. Role 1 pairs the stack segment with `offset`. Role 2 pairs the data segment with `offset`.
- R3: Role 3 (string source) forms the address from the data segment plus the source pointer. Role 4 (string destination) forms it from the extra segment plus the destination pointer, not from the data segment.
- R4: The write port select codes are: 0 code segment, 1 data segment, 2 extra segment, 3 stack segment, 4 source pointer, 5 destination pointer, 6 count. Code 7 loads the direction bit from `wr_data[0]`. A write is visible after the next rising clock edge.
- R5: Reset, active low, clears every register. After reset, every role gives address 0, the count is 0, `str_done` is 1, and the direction bit is 0.
- R6: An accepted step changes both pointers by 1 when `elem_word` is 0 and by 2 when `elem_word` is 1. The pointers increase when the direction bit is 0 and decrease when it is 1.
- R7: Pointer stepping wraps modulo 2^16 in both directions.
- R8: An accepted step with `rep_en` = 1 decrements the count by one.
- R9: `str_done` is 1 exactly when the count is 0. A step with `rep_en` = 1 and a zero count changes neither the pointers nor the count.
- R10: An accepted step with `rep_en` = 0 leaves the count unchanged.
- R11: A step that arrives in the same cycle as a write is dropped. Only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (see R4) |
| wr_data | input | 16 | Write data |
| role | input | 3 | Addressing role, codes 0 to 4 |
| offset | input | 16 | Offset for roles 0 to 2 |
| step | input | 1 | Element step request |
| elem_word | input | 1 | Element size: 1 selects word, 0 selects byte |
| rep_en | input | 1 | Repeat mode enable |
| phys_addr | output | 20 | Physical address |
| rep_count | output | 16 | Current repeat count |
| str_done | output | 1 | Count is exhausted |

## Verification
A corrupted pointer or segment register shows up on `phys_addr` as soon as the matching role is selected, because the address path is purely combinational from the registers. A stepping fault, such as a wrong size, wrong direction, a missing wrap or a dropped step, appears one clock after the step as a shifted string address. Counter faults appear on `rep_count` and `str_done` after that same edge. A step that leaks through at a zero count moves the string address although it should stay frozen.

// File: rtl/sag_pkg.sv
// Package: shared role codes and register select codes for the segmented
// address generator. Assumes 3-bit role and select fields.
package sag_pkg;
    typedef enum logic [2:0] {
        ROLE_CODE  = 3'd0,
        ROLE_STACK = 3'd1,
        ROLE_DATA  = 3'd2,
        ROLE_SRC   = 3'd3,
        ROLE_DST   = 3'd4
    } role_e;

    localparam logic [2:0] SEL_CSEG = 3'd0;
    localparam logic [2:0] SEL_DSEG = 3'd1;
    localparam logic [2:0] SEL_XSEG = 3'd2;
    localparam logic [2:0] SEL_SSEG = 3'd3;
    localparam logic [2:0] SEL_SRC  = 3'd4;
    localparam logic [2:0] SEL_DST  = 3'd5;
    localparam logic [2:0] SEL_CNT  = 3'd6;
    localparam logic [2:0] SEL_DIR  = 3'd7;

    localparam int NUM_SEG = 4;
endpackage

// File: rtl/sag_regs.sv
// Register file: four segment registers, source and destination pointers,
// repeat count and direction bit. A write has priority over a step update.
// Assumes the update inputs are only valid when upd_en is high.
module sag_regs
    import sag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [W-1:0]        wr_data,
    input  logic                upd_en,
    input  logic                upd_cnt,
    input  logic [W-1:0]        src_nxt,
    input  logic [W-1:0]        dst_nxt,
    input  logic [W-1:0]        cnt_nxt,
    output logic [W-1:0]        seg_q [NUM_SEG],
    output logic [W-1:0]        src_q,
    output logic [W-1:0]        dst_q,
    output logic [W-1:0]        cnt_q,
    output logic                dir_q
);
    // One register per segment, each written only through its own select code.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && wr_sel == 3'(g))
                seg_q[g] <= wr_data;
        end
    end

    // Pointer registers: a write wins, otherwise take the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_SRC) src_q <= wr_data;
            if (wr_sel == SEL_DST) dst_q <= wr_data;
        end else if (upd_en) begin
            src_q <= src_nxt;
            dst_q <= dst_nxt;
        end
    end

    // Count register and direction bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CNT) cnt_q <= wr_data;
            if (wr_sel == SEL_DIR) dir_q <= wr_data[0];
        end else if (upd_en && upd_cnt) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/sag_step.sv
// Step logic: decides whether an element step is accepted and computes the
// next pointer and count values. Pointer arithmetic wraps modulo 2^W.
module sag_step #(
    parameter int W = 16
) (
    input  logic         step,
    input  logic         wr_en,
    input  logic         rep_en,
    input  logic         elem_word,
    input  logic         dir,
    input  logic [W-1:0] src_q,
    input  logic [W-1:0] dst_q,
    input  logic [W-1:0] cnt_q,
    output logic         upd_en,
    output logic         upd_cnt,
    output logic [W-1:0] src_nxt,
    output logic [W-1:0] dst_nxt,
    output logic [W-1:0] cnt_nxt,
    output logic         done
);
    logic [W-1:0] delta;

    // Acceptance: no write in flight, and in repeat mode a non-zero count.
    always_comb begin
        done    = (cnt_q == '0);
        upd_en  = step && !wr_en && !(rep_en && done);
        upd_cnt = rep_en;
    end

    // Next values: size-scaled step in the held direction, count minus one.
    always_comb begin
        delta   = elem_word ? W'(2) : W'(1);
        src_nxt = dir ? (src_q - delta) : (src_q + delta);
        dst_nxt = dir ? (dst_q - delta) : (dst_q + delta);
        cnt_nxt = cnt_q - W'(1);
    end
endmodule

// File: rtl/sag_addr.sv
// Address former: picks the segment and offset for the role and forms the
// shifted-base sum, truncated to the physical width. Unused role codes fall
// back to the data segment with the offset input.
module sag_addr
    import sag_pkg::*;
#(
    parameter int W     = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = W + SHIFT
) (
    input  logic [2:0]    role,
    input  logic [W-1:0]  offset,
    input  logic [W-1:0]  seg_q [NUM_SEG],
    input  logic [W-1:0]  src_q,
    input  logic [W-1:0]  dst_q,
    output logic [PA_W-1:0] phys_addr
);
    logic [W-1:0] base;
    logic [W-1:0] ofs;

    // Role decode: segment and offset source.
    always_comb begin
        case (role)
            ROLE_CODE:  begin base = seg_q[SEL_CSEG]; ofs = offset; end
            ROLE_STACK: begin base = seg_q[SEL_SSEG]; ofs = offset; end
            ROLE_SRC:   begin base = seg_q[SEL_DSEG]; ofs = src_q;  end
            ROLE_DST:   begin base = seg_q[SEL_XSEG]; ofs = dst_q;  end
            default:    begin base = seg_q[SEL_DSEG]; ofs = offset; end
        endcase
    end

    // Shifted base plus zero-extended offset, wrapping at PA_W bits.
    always_comb begin
        phys_addr = {base, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ofs};
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Top: segmented address generator with string pointer stepping. Ties the
// register file, the step logic and the address former together. Assumes a
// single clock and a synchronous active-low reset.
module seg_addr_gen
    import sag_pkg::*;
#(
    parameter int W     = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = W + SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [W-1:0]    wr_data,
    input  logic [2:0]      role,
    input  logic [W-1:0]    offset,
    input  logic            step,
    input  logic            elem_word,
    input  logic            rep_en,
    output logic [PA_W-1:0] phys_addr,
    output logic [W-1:0]    rep_count,
    output logic            str_done
);
    logic [W-1:0] seg_q [NUM_SEG];
    logic [W-1:0] src_q, dst_q, cnt_q;
    logic [W-1:0] src_nxt, dst_nxt, cnt_nxt;
    logic         dir_q, upd_en, upd_cnt;

    sag_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_en(upd_en), .upd_cnt(upd_cnt),
        .src_nxt(src_nxt), .dst_nxt(dst_nxt), .cnt_nxt(cnt_nxt),
        .seg_q(seg_q), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
        .dir_q(dir_q)
    );

    sag_step #(.W(W)) u_step (
        .step(step), .wr_en(wr_en), .rep_en(rep_en), .elem_word(elem_word),
        .dir(dir_q), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
        .upd_en(upd_en), .upd_cnt(upd_cnt), .src_nxt(src_nxt),
        .dst_nxt(dst_nxt), .cnt_nxt(cnt_nxt), .done(str_done)
    );

    sag_addr #(.W(W), .SHIFT(SHIFT)) u_addr (
        .role(role), .offset(offset), .seg_q(seg_q), .src_q(src_q),
        .dst_q(dst_q), .phys_addr(phys_addr)
    );

    // Count is brought out as-is.
    always_comb rep_count = cnt_q;
endmodule

// File: rtl/sag_checker.sv
// Checker: temporal properties on the top-level ports of seg_addr_gen.
// Attached by the bind statement at the end of this file.
module sag_checker #(
    parameter int W     = 16,
    parameter int PA_W  = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      wr_sel,
    input logic [W-1:0]    wr_data,
    input logic [2:0]      role,
    input logic [W-1:0]    offset,
    input logic            step,
    input logic            rep_en,
    input logic [PA_W-1:0] phys_addr,
    input logic [W-1:0]    rep_count,
    input logic            str_done
);
    AST_ADDR_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (role <= 3'd2) |-> (phys_addr[3:0] == offset[3:0])); // R1

    AST_CNT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd6) |=> (rep_count == $past(wr_data))); // R4

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rep_en && !wr_en && rep_count != '0) |=> (rep_count == $past(rep_count) - W'(1))); // R8

    AST_ZERO_STEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rep_en && !wr_en && str_done) |=> $stable(rep_count)); // R9

    AST_NOREP_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rep_en && !wr_en) |=> $stable(rep_count)); // R10
endmodule

bind seg_addr_gen sag_checker #(.W(W), .PA_W(PA_W)) u_sag_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .role(role), .offset(offset), .step(step),
    .rep_en(rep_en), .phys_addr(phys_addr), .rep_count(rep_count),
    .str_done(str_done)
);

// File: tb/seg_addr_gen_tb.sv
// Bench: table-driven address checks, then directed stepping, corner and
// reset tests. Inputs change on falling edges; outputs are sampled 1 ns later.
module seg_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  role = '0;
    logic [15:0] offset = '0;
    logic        step = 1'b0;
    logic        elem_word = 1'b0;
    logic        rep_en = 1'b0;
    logic [19:0] phys_addr;
    logic [15:0] rep_count;
    logic        str_done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .role(role), .offset(offset), .step(step),
        .elem_word(elem_word), .rep_en(rep_en), .phys_addr(phys_addr),
        .rep_count(rep_count), .str_done(str_done)
    );

    always #2 clk = ~clk;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // {select, segment value, role, offset, expected address}
    localparam logic [57:0] VEC [6] = '{
        {3'd0, 16'h1234, 3'd0, 16'h0005, 20'h12345},
        {3'd3, 16'hFFFF, 3'd1, 16'h0010, 20'h00000},
        {3'd1, 16'hABCD, 3'd2, 16'hFFFF, 20'hBBCCF},
        {3'd0, 16'h0000, 3'd0, 16'h1234, 20'h01234},
        {3'd3, 16'h8000, 3'd1, 16'h8000, 20'h88000},
        {3'd1, 16'h0001, 3'd2, 16'h0001, 20'h00011}
    };

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step_once(input logic word, input logic rep);
        @(negedge clk);
        step = 1'b1; elem_word = word; rep_en = rep;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic chk_addr(input string req, input logic [2:0] r,
                            input logic [15:0] o, input logic [19:0] exp);
        role = r; offset = o;
        #1;
        checks = checks + 1;
        if (phys_addr !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: role %0d addr actual %h expected %h", req, r, phys_addr, exp);
        end
    endtask

    task automatic chk_cnt(input string req, input logic [15:0] exp, input logic exp_done);
        #1;
        checks = checks + 1;
        if (rep_count !== exp || str_done !== exp_done) begin
            fails = fails + 1;
            $display("FAIL %s: count/done actual %h/%b expected %h/%b",
                     req, rep_count, str_done, exp, exp_done);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset state
        chk_cnt("R5", 16'h0000, 1'b1);
        chk_addr("R5", 3'd3, 16'h0000, 20'h00000);
        chk_addr("R5", 3'd4, 16'h0000, 20'h00000);

        // R1, R2: table of segment/offset pairs
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][57:55], VEC[i][54:39]);
            chk_addr("R1/R2", VEC[i][38:36], VEC[i][35:20], VEC[i][19:0]);
        end

        // R3, R4: string roles use the data and extra segments
        wr(3'd1, 16'h1000);
        wr(3'd2, 16'h2000);
        wr(3'd4, 16'h0010);
        wr(3'd5, 16'h0020);
        wr(3'd6, 16'h0003);
        chk_addr("R3", 3'd3, 16'h0000, 20'h10010);
        chk_addr("R3", 3'd4, 16'h0000, 20'h20020);
        chk_addr("R3", 3'd2, 16'h0020, 20'h10020);
        chk_cnt("R4", 16'h0003, 1'b0);

        // R6, R8: byte step up, then word step up
        step_once(1'b0, 1'b1);
        chk_addr("R6", 3'd3, 16'h0000, 20'h10011);
        chk_addr("R6", 3'd4, 16'h0000, 20'h20021);
        chk_cnt("R8", 16'h0002, 1'b0);
        step_once(1'b1, 1'b1);
        chk_addr("R6", 3'd3, 16'h0000, 20'h10013);
        chk_cnt("R8", 16'h0001, 1'b0);

        // R6, R9: direction down, count reaches zero
        wr(3'd7, 16'h0001);
        step_once(1'b0, 1'b1);
        chk_addr("R6", 3'd4, 16'h0000, 20'h20022);
        chk_cnt("R9", 16'h0000, 1'b1);

        // R9: step at zero count in repeat mode is ignored
        step_once(1'b0, 1'b1);
        chk_addr("R9", 3'd3, 16'h0000, 20'h10012);
        chk_addr("R9", 3'd4, 16'h0000, 20'h20022);
        chk_cnt("R9", 16'h0000, 1'b1);

        // R10: no-repeat step moves pointers, count held
        step_once(1'b1, 1'b0);
        chk_addr("R10", 3'd3, 16'h0000, 20'h10010);
        chk_cnt("R10", 16'h0000, 1'b1);

        // R7: wrap upward and downward
        wr(3'd4, 16'hFFFF);
        wr(3'd7, 16'h0000);
        step_once(1'b0, 1'b0);
        chk_addr("R7", 3'd3, 16'h0000, 20'h10000);
        wr(3'd5, 16'h0000);
        wr(3'd7, 16'h0001);
        step_once(1'b1, 1'b0);
        chk_addr("R7", 3'd3, 16'h0000, 20'h1FFFE);
        chk_addr("R7", 3'd4, 16'h0000, 20'h2FFFE);

        // R11: write and step together, step dropped
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd6; wr_data = 16'h0005;
        step = 1'b1; rep_en = 1'b1; elem_word = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; step = 1'b0;
        chk_cnt("R11", 16'h0005, 1'b0);
        chk_addr("R11", 3'd3, 16'h0000, 20'h1FFFE);

        // R5: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_cnt("R5", 16'h0000, 1'b1);
        chk_addr("R5", 3'd4, 16'h0000, 20'h00000);
        chk_addr("R5", 3'd0, 16'h0000, 20'h00000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule